// File: doc/BRIEF.md
# Compare-Match Period Timer with Toggling Output

This block is a free-running 32-bit up-counter that marks a period end each time its count has reached a programmable compare value. The counter advances once per prescaled tick. On the tick after the count has been equal to the compare value, the counter returns to zero. At the same moment the output pin flips to its other level and a sticky interrupt flag is raised. The flag stays set until software clears it.

Software sets the compare value and the prescale exponent, and picks the idle level of the pin with a polarity bit. While the timer is stopped, software may preset the counter. A preset value affects only the first period. Every later period runs from zero up to the compare value, so the period in ticks is the compare value minus the starting count, plus one, taken modulo 2^32. A complementary pin always carries the inverse of the main pin.

Top module: `cmp_period_timer`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0, `irq_flag` is 0, and `tmr_out` equals `pol`.
- R2: While `en` is 1, `count` changes once every 2^N clock cycles, where N is `presc_sel`. Any `presc_sel` value above 12 behaves as 12, which gives a 4096-cycle spacing.
- R3: On a tick where `count` equals `cmp_val`, `count` becomes 0. On any other tick it increments by one. The period is therefore `cmp_val` minus the starting count, plus one, ticks.
- R4: A starting count above `cmp_val` counts up through 0xFFFF_FFFF and wraps to 0 without a period end. It then continues up to `cmp_val`.
- R5: At each period end, `tmr_out` inverts if `out_en` is 1. It keeps its level if `out_en` is 0.
- R6: `tmr_out_n` is always the inverse of `tmr_out`.
- R7: Each period end sets `irq_flag` in the same edge where `count` returns to 0. `irq_flag` stays 1 until `flag_clr` is sampled high.
- R8: If `flag_clr` is high in the cycle of a period end, `irq_flag` stays 1.
- R9: While `en` is 0, `count` and `tmr_out` hold their values. A `ld_stb` pulse loads `ld_val` into `count` and returns `tmr_out` to the level of `pol`. A `ld_stb` pulse while `en` is 1 is ignored.
- R10: Enabling restarts the prescaler. The first count change comes at the 2^N-th clock edge at which `en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable |
| presc_sel | input | 4 | Prescale exponent N (divide by 2^N, capped at 12) |
| pol | input | 1 | Idle level of the output pin |
| cmp_val | input | 32 | Compare value |
| out_en | input | 1 | Allows the pin to toggle at a period end |
| ld_stb | input | 1 | Loads the counter while stopped |
| ld_val | input | 32 | Value loaded by `ld_stb` |
| flag_clr | input | 1 | Clears the interrupt flag |
| tmr_out | output | 1 | Timer output pin |
| tmr_out_n | output | 1 | Complementary output pin |
| irq_flag | output | 1 | Sticky period-end flag |
| count | output | 32 | Current counter value |

## Verification
Directed runs pair small compare values with a zero start and with a start just below the 32-bit limit. This separates a plain match-and-restart from a wrap that must not raise the flag. Prescale exponents 0, 2, 3 and an out-of-range 15 are timed edge by edge, which shows whether the divider and its cap are right and whether enabling restarts it. A clear placed on the exact period-end cycle shows whether the set takes priority. Loads issued while running and while stopped show whether the gating of the load is right. A long random run then toggles enable, clear, load and pin enable against a bench model cycle by cycle.

// File: rtl/cpt_pkg.sv
// Shared constants and helpers for the compare-match period timer.
// Assumes callers size the prescale select to SEL_W bits.
package cpt_pkg;
    localparam int CNT_W  = 32;
    localparam int SEL_W  = 4;
    localparam int PS_MAX = 12;

    // Clamp a prescale exponent to the largest supported value.
    function automatic logic [SEL_W-1:0] clamp_sel(input logic [SEL_W-1:0] sel);
        return (sel > SEL_W'(PS_MAX)) ? SEL_W'(PS_MAX) : sel;
    endfunction
endpackage

// File: rtl/cpt_prescale.sv
// Prescaler: produces a one-cycle tick every 2^N clocks while enabled.
// Assumes N is already meaningful up to PS_MAX; larger selects are capped.
// The divider count is held at zero while disabled, so enabling restarts it.
module cpt_prescale
    import cpt_pkg::*;
#(
    parameter int PMAX = PS_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PW = (PMAX > 0) ? PMAX : 1;

    logic [PW-1:0]    pcnt;
    logic [PW-1:0]    mask;
    logic [SEL_W-1:0] n_eff;

    // Compute the low-bit mask for the selected divide ratio.
    always_comb begin
        n_eff = (sel > SEL_W'(PMAX)) ? SEL_W'(PMAX) : sel;
        mask  = ~({PW{1'b1}} << n_eff);
        tick  = en && ((pcnt & mask) == mask);
    end

    // Free-run the divider while enabled, park it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   pcnt <= '0;
        else if (en)  pcnt <= pcnt + 1'b1;
        else          pcnt <= '0;
    end

    AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (pcnt == '0)); // R10
    AST_PRESC_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pcnt == '0)); // R10
endmodule

// File: rtl/cpt_counter.sv
// Counter and match: advances on each tick and returns to zero on the tick
// where it equals the compare value, flagging a period end on that tick.
// Assumes tick is only high while enabled; load is honoured only when stopped.
module cpt_counter
    import cpt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         ld_stb,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] count,
    output logic         evt,
    output logic         ld_take
);
    // Decode the period end and the accepted load.
    always_comb begin
        evt     = tick && (count == cmp_val);
        ld_take = !en && ld_stb;
    end

    // Update the count: load, restart on match, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (ld_take)  count <= ld_val;
        else if (evt)      count <= '0;
        else if (tick)     count <= count + 1'b1;
    end

    AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == cmp_val) |=> (count == '0)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != cmp_val) |=> (count == $past(count) + 1'b1)); // R3
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld_stb) |=> $stable(count)); // R9
    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick); // R9
endmodule

// File: rtl/cpt_outflag.sv
// Output pin and interrupt flag: flips the pin level at each period end when
// allowed, and holds a sticky flag that a set beats a same-cycle clear.
// Assumes evt is a single-cycle pulse and ld_rst comes only while stopped.
module cpt_outflag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic out_en,
    input  logic ld_rst,
    input  logic pol,
    input  logic clr,
    output logic pin,
    output logic pin_n,
    output logic flag
);
    logic flipped;

    // Track whether the pin is away from its idle level.
    always_ff @(posedge clk) begin
        if (!rst_n)              flipped <= 1'b0;
        else if (ld_rst)         flipped <= 1'b0;
        else if (evt && out_en)  flipped <= ~flipped;
    end

    // Sticky flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (evt)   flag <= 1'b1;
        else if (clr)   flag <= 1'b0;
    end

    // Drive the pin pair from the idle level and the flip state.
    always_comb begin
        pin   = pol ^ flipped;
        pin_n = ~pin;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag); // R8
    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!(evt && out_en) && !ld_rst) |=> $stable(flipped)); // R5
    AST_PIN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && out_en && !ld_rst) |=> (flipped != $past(flipped))); // R5
endmodule

// File: rtl/cmp_period_timer.sv
// Top of the compare-match period timer: prescaler, counter with match
// restart, and the output/flag stage. Assumes all inputs are synchronous.
module cmp_period_timer
    import cpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             pol,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             out_en,
    input  logic             ld_stb,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             flag_clr,
    output logic             tmr_out,
    output logic             tmr_out_n,
    output logic             irq_flag,
    output logic [CNT_W-1:0] count
);
    logic tick;
    logic evt;
    logic ld_take;

    cpt_prescale #(.PMAX(PS_MAX)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .sel   (presc_sel),
        .tick  (tick)
    );

    cpt_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tick    (tick),
        .ld_stb  (ld_stb),
        .ld_val  (ld_val),
        .cmp_val (cmp_val),
        .count   (count),
        .evt     (evt),
        .ld_take (ld_take)
    );

    cpt_outflag u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .out_en (out_en),
        .ld_rst (ld_take),
        .pol    (pol),
        .clr    (flag_clr),
        .pin    (tmr_out),
        .pin_n  (tmr_out_n),
        .flag   (irq_flag)
    );

    AST_EVT_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (count == '0 && irq_flag)); // R7
    AST_WRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '1 && cmp_val != '1) |=> (count == '0)); // R4
endmodule

// File: tb/tb_cmp_period_timer.sv
module tb_cmp_period_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  presc_sel = '0;
    logic        pol = 1'b0;
    logic [31:0] cmp_val = '0;
    logic        out_en = 1'b1;
    logic        ld_stb = 1'b0;
    logic [31:0] ld_val = '0;
    logic        flag_clr = 1'b0;
    logic        tmr_out, tmr_out_n, irq_flag;
    logic [31:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_period_timer dut (
        .clk(clk), .rst_n(rst_n), .en(en), .presc_sel(presc_sel), .pol(pol),
        .cmp_val(cmp_val), .out_en(out_en), .ld_stb(ld_stb), .ld_val(ld_val),
        .flag_clr(flag_clr), .tmr_out(tmr_out), .tmr_out_n(tmr_out_n),
        .irq_flag(irq_flag), .count(count)
    );

    // Bench reference state, built from the requirements.
    logic [11:0] m_pc;
    logic [31:0] m_cnt;
    logic        m_flip, m_flag;

    function automatic logic [11:0] mask_of(input logic [3:0] s);
        int n = (s > 4'd12) ? 12 : int'(s);
        return 12'((1 << n) - 1);
    endfunction

    always @(posedge clk) begin
        logic tk, ev;
        if (!rst_n) begin
            m_pc <= '0; m_cnt <= '0; m_flip <= 1'b0; m_flag <= 1'b0;
        end else begin
            tk = en && ((m_pc & mask_of(presc_sel)) == mask_of(presc_sel));
            ev = tk && (m_cnt == cmp_val);
            m_pc <= en ? m_pc + 12'd1 : 12'd0;
            if (!en && ld_stb) begin
                m_cnt <= ld_val; m_flip <= 1'b0;
            end else begin
                if (ev) m_cnt <= '0; else if (tk) m_cnt <= m_cnt + 32'd1;
                if (ev && out_en) m_flip <= ~m_flip;
            end
            m_flag <= ev ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        check(count == m_cnt, "R3", "count", count, m_cnt);
        check(tmr_out == (pol ^ m_flip), "R5", "tmr_out", tmr_out, pol ^ m_flip);
        check(tmr_out_n == ~tmr_out, "R6", "tmr_out_n", tmr_out_n, ~tmr_out);
        check(irq_flag == m_flag, "R7", "irq_flag", irq_flag, m_flag);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            compare_model();
        end
    endtask

    task automatic load(input logic [31:0] v);
        en = 1'b0; ld_stb = 1'b1; ld_val = v;
        step(1);
        ld_stb = 1'b0;
    endtask

    // Cycles until count next changes, at most lim.
    task automatic cycles_to_change(input int lim, output int n);
        logic [31:0] c0 = count;
        n = 0;
        while (count == c0 && n < lim) begin step(1); n++; end
    endtask

    initial begin
        int n;
        void'($urandom(32'd1234));
        step(2);
        check(count == 0, "R1", "reset count", count, 0);
        check(irq_flag == 0, "R1", "reset flag", irq_flag, 0);
        check(tmr_out == pol, "R1", "reset pin", tmr_out, pol);
        rst_n = 1'b1;
        step(1);

        // R3 / R5 / R7: cmp=3 from zero, period of four ticks.
        cmp_val = 32'd3; presc_sel = 4'd0; en = 1'b1;
        step(3);
        check(count == 3 && irq_flag == 0, "R3", "before match", count, 3);
        step(1);
        check(count == 0 && irq_flag == 1, "R3", "restart after match", count, 0);
        check(tmr_out == ~pol, "R5", "pin flipped", tmr_out, ~pol);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        check(irq_flag == 0, "R7", "flag cleared", irq_flag, 0);

        // R8: clear on the period-end cycle.
        while (count != cmp_val) step(1);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        check(irq_flag == 1, "R8", "set beats clear", irq_flag, 1);

        // R9: load ignored while running.
        ld_stb = 1'b1; ld_val = 32'h55; step(1); ld_stb = 1'b0;
        check(count != 32'h55, "R9", "load while running", count, 0);

        // R9: stopped holds; load resets pin.
        en = 1'b0; step(1);
        n = int'(count); step(5);
        check(count == 32'(n), "R9", "hold while stopped", count, n);
        load(32'hFFFF_FFFE);
        check(count == 32'hFFFF_FFFE && tmr_out == pol, "R9", "load", count, 32'hFFFF_FFFE);

        // R4: wrap past the limit without an event, cmp=1.
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        cmp_val = 32'd1; en = 1'b1;
        step(2);
        check(count == 0 && irq_flag == 0, "R4", "wrap no event", irq_flag, 0);
        step(2);
        check(count == 0 && irq_flag == 1, "R4", "event after wrap", irq_flag, 1);

        // R5: out_en low keeps the pin.
        out_en = 1'b0; n = tmr_out; step(2);
        check(tmr_out == n && irq_flag == 1, "R5", "no toggle when disabled", tmr_out, n);
        out_en = 1'b1;

        // R2: divide by 8 and capped 15 -> 4096.
        cmp_val = 32'hFFFF_0000; presc_sel = 4'd3;
        cycles_to_change(100, n); cycles_to_change(100, n);
        check(n == 8, "R2", "divide by 8", n, 8);
        presc_sel = 4'd15;
        cycles_to_change(5000, n); cycles_to_change(5000, n);
        check(n == 4096, "R2", "cap at 12", n, 4096);

        // R10: enable restarts the prescaler, N=2.
        en = 1'b0; presc_sel = 4'd2; step(3);
        en = 1'b1;
        cycles_to_change(100, n);
        check(n == 4, "R10", "first change after enable", n, 4);

        // Random phase against the bench model.
        presc_sel = 4'd0;
        for (int it = 0; it < 4000; it++) begin
            if (($urandom % 200) == 0) begin
                load($urandom % 20);
                cmp_val = $urandom % 16;
                presc_sel = 4'($urandom % 3);
                pol = 1'($urandom);
                en = 1'b1;
            end
            flag_clr = (($urandom % 8) == 0);
            out_en   = (($urandom % 6) != 0);
            en       = (($urandom % 30) != 0);
            ld_stb   = (($urandom % 40) == 0);
            ld_val   = $urandom % 20;
            step(1);
        end
        flag_clr = 1'b0; ld_stb = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule